// File: doc/BRIEF.md
# HDLC Transmit Frame-End Sequencer

This block takes one transmit descriptor at a time and writes the frame's bytes, in order, into a per-channel transmit byte FIFO. A descriptor gives the data length, a delay flag and a pad count. The block can first wait a programmed signal-unit delay. It then passes the data bytes from a byte source through to the FIFO, writes one closing flag, and writes the requested number of idle pad bytes. Only after the last of those writes does it raise a one-cycle buffer-done interrupt. The pad count lets software hold the interrupt back until the flag has drained out of the FIFO. For a single channel the FIFO holds 4 bytes. For a channel built from grouped slots it holds twice the slot count. A pad count at least as large as that depth therefore guarantees the flag has left the line when the interrupt fires.

The delay is measured in units of 512 µs. Each unit is TICK_DIV clock cycles, so a 50 MHz clock needs a TICK_DIV of 25600. Data bytes are requested one at a time through a request/valid handshake. Every write to the FIFO waits for FIFO ready. The descriptor fields are only read, never written back.

Top module: `hdlc_txfe_seq`

## Requirements
- R1: An accepted descriptor of length N (N >= 1) writes exactly N data bytes to the FIFO. They are the source bytes in the order supplied, with none skipped or repeated.
- R2: The data bytes are followed by exactly one closing-flag write of value 0x7E.
- R3: After the flag, the block writes exactly the descriptor's 4-bit pad count (0 to 15) of pad bytes. A pad byte is 0x7E when `cfg_idle_ff` was 0 at acceptance and 0xFF when it was 1.
- R4: `irq` is a single-cycle pulse, once per accepted descriptor, in the cycle right after the last FIFO write. That last write is the flag itself when the pad count is 0.
- R5: A descriptor is accepted in a cycle where `desc_valid` and `desc_ready` are both high. If `desc_dly` and `cfg_dly_en` are both 1 at acceptance, the first data write occurs `cfg_dly_mult`*TICK_DIV cycles after the acceptance cycle. Otherwise, and also when `cfg_dly_mult` is 0, it occurs in the cycle right after acceptance, provided the source and FIFO are ready.
- R6: When `cfg_dly_en` is 0, `desc_dly` has no effect on when the first data byte is written.
- R7: A descriptor with length 0 is consumed in its cycle with an `err` pulse. It causes no FIFO write and no `irq`, and `desc_ready` stays high.
- R8: While `fifo_rdy` is low, `fifo_wr` and `data_req` stay low. Stalls, whether on `fifo_rdy` or `data_valid`, neither drop nor duplicate any byte.
- R9: `desc_ready` is high in the cycle right after the `irq` pulse, and no FIFO write happens in that cycle.
- R10: While reset is asserted, `desc_ready` is high and `fifo_wr`, `data_req`, `irq` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_len | input | LEN_W | Number of data bytes |
| desc_dly | input | 1 | Request signal-unit delay before the frame |
| desc_pad | input | 4 | Number of pad bytes after the flag |
| cfg_idle_ff | input | 1 | Pad value select: 0 gives 0x7E, 1 gives 0xFF |
| cfg_dly_en | input | 1 | Enable the per-buffer delay option |
| cfg_dly_mult | input | DLY_W | Delay in 512 µs units |
| data_req | output | 1 | Requesting the next data byte |
| data_valid | input | 1 | Data byte present |
| data_byte | input | 8 | Data byte |
| fifo_rdy | input | 1 | FIFO can accept a byte |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| irq | output | 1 | Buffer-done pulse |
| err | output | 1 | Zero-length descriptor pulse |

## Verification
The bench builds the block with TICK_DIV = 4, so one 512 µs unit lasts four cycles. Delays of one to three units can then be timed to the exact cycle, where the default would need tens of thousands of cycles per unit. LEN_W and DLY_W keep their defaults. Frames of up to seven bytes with pad counts up to 15 cover both pad values, zero pads, the longest pad run, and the delay flag with the option both enabled and disabled. Stall patterns on `fifo_rdy` and `data_valid` check that ordering holds under back-pressure.

// File: rtl/hdlc_txfe_seq.sv
module hdlc_txfe_seq #(
  parameter int LEN_W    = 16,
  parameter int DLY_W    = 8,
  parameter int TICK_DIV = 25600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_dly,
  input  logic [3:0]       desc_pad,
  input  logic             cfg_idle_ff,
  input  logic             cfg_dly_en,
  input  logic [DLY_W-1:0] cfg_dly_mult,
  output logic             data_req,
  input  logic             data_valid,
  input  logic [7:0]       data_byte,
  input  logic             fifo_rdy,
  output logic             fifo_wr,
  output logic [7:0]       fifo_data,
  output logic             irq,
  output logic             err
);

  localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_DATA, S_FLAG, S_PAD, S_DONE} st_t;

  st_t              st;
  logic [LEN_W-1:0] len_left;
  logic [3:0]       pad_left;
  logic [7:0]       pad_byte;
  logic [DLY_W-1:0] units;
  logic [PS_W-1:0]  presc;

  wire take   = (st == S_IDLE) && desc_valid;
  wire zero   = (desc_len == '0);
  wire dly_go = desc_dly && cfg_dly_en && (cfg_dly_mult != '0);
  wire tick   = (presc == PS_W'(TICK_DIV - 1));

  assign desc_ready = (st == S_IDLE);
  assign err        = take && zero;
  assign irq        = (st == S_DONE);
  assign data_req   = (st == S_DATA) && fifo_rdy;
  assign fifo_wr    = (data_req && data_valid) ||
                      (((st == S_FLAG) || (st == S_PAD)) && fifo_rdy);
  assign fifo_data  = (st == S_DATA) ? data_byte :
                      (st == S_FLAG) ? FLAG : pad_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      len_left <= '0;
      pad_left <= '0;
      pad_byte <= FLAG;
      units    <= '0;
      presc    <= '0;
    end else begin
      case (st)
        S_IDLE: if (take && !zero) begin
          len_left <= desc_len;
          pad_left <= desc_pad;
          pad_byte <= cfg_idle_ff ? 8'hFF : FLAG;
          units    <= cfg_dly_mult;
          presc    <= '0;
          st       <= dly_go ? S_WAIT : S_DATA;
        end
        S_WAIT: begin
          presc <= tick ? '0 : presc + 1'b1;
          if (tick) begin
            units <= units - 1'b1;
            if (units == DLY_W'(1)) st <= S_DATA;
          end
        end
        S_DATA: if (fifo_wr) begin
          len_left <= len_left - 1'b1;
          if (len_left == LEN_W'(1)) st <= S_FLAG;
        end
        S_FLAG: if (fifo_rdy) st <= (pad_left == 4'd0) ? S_DONE : S_PAD;
        S_PAD: if (fifo_rdy) begin
          pad_left <= pad_left - 1'b1;
          if (pad_left == 4'd1) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hdlc_txfe_seq_chk.sv
module hdlc_txfe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_wr,
  input logic       fifo_rdy,
  input logic       data_req,
  input logic [7:0] fifo_data,
  input logic       irq,
  input logic       err,
  input logic       desc_ready
);

  AST_WR_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) fifo_wr |-> fifo_rdy); // R8
  AST_REQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) data_req |-> fifo_rdy); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R4
  AST_IRQ_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(fifo_wr)); // R4
  AST_IDLE_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n) irq |=> (desc_ready && !fifo_wr)); // R9
  AST_ERR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) err |=> (!fifo_wr && desc_ready)); // R7
  AST_TRAILER_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !data_req) |-> (fifo_data == 8'h7E || fifo_data == 8'hFF)); // R3

endmodule

bind hdlc_txfe_seq hdlc_txfe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_rdy(fifo_rdy),
  .data_req(data_req), .fifo_data(fifo_data), .irq(irq), .err(err),
  .desc_ready(desc_ready)
);

// File: tb/hdlc_txfe_seq_bench.sv
module hdlc_txfe_seq_bench;
  localparam int TICK = 4;
  localparam int NV   = 8;
  // {len[7:0], pad[3:0], dly, en, ff, mult[3:0], stall}
  localparam logic [19:0] VEC [NV] = '{
    {8'd1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
    {8'd5, 4'd4,  1'b0, 1'b0, 1'b1, 4'd0, 1'b0},
    {8'd3, 4'd15, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0},
    {8'd2, 4'd1,  1'b1, 1'b1, 1'b1, 4'd3, 1'b0},
    {8'd4, 4'd2,  1'b1, 1'b0, 1'b0, 4'd3, 1'b0},
    {8'd6, 4'd3,  1'b0, 1'b0, 1'b1, 4'd0, 1'b1},
    {8'd2, 4'd0,  1'b1, 1'b1, 1'b0, 4'd0, 1'b0},
    {8'd7, 4'd5,  1'b1, 1'b1, 1'b0, 4'd1, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic desc_valid = 0, desc_dly = 0, cfg_idle_ff = 0, cfg_dly_en = 0;
  logic [15:0] desc_len = '0;
  logic [3:0] desc_pad = '0;
  logic [7:0] cfg_dly_mult = '0, data_byte = '0;
  logic data_valid = 1, fifo_rdy = 1;
  logic desc_ready, data_req, fifo_wr, irq, err;
  logic [7:0] fifo_data;

  always #10 clk = ~clk;

  hdlc_txfe_seq #(.LEN_W(16), .DLY_W(8), .TICK_DIV(TICK)) u_hdlc_txfe_seq (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_len(desc_len), .desc_dly(desc_dly), .desc_pad(desc_pad),
    .cfg_idle_ff(cfg_idle_ff), .cfg_dly_en(cfg_dly_en), .cfg_dly_mult(cfg_dly_mult),
    .data_req(data_req), .data_valid(data_valid), .data_byte(data_byte),
    .fifo_rdy(fifo_rdy), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .irq(irq), .err(err));

  int cyc = 0, nchk = 0, nfail = 0;
  int ncap = 0, nirq = 0, nerr = 0, irq_cyc = 0, idx = 0;
  logic took = 0;
  logic [7:0] cap [64];
  int capcyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fifo_wr && ncap < 64) begin
      cap[ncap] = fifo_data;
      capcyc[ncap] = cyc;
      ncap = ncap + 1;
      if (data_req && data_valid) took = 1;
    end
    if (irq) begin nirq = nirq + 1; irq_cyc = cyc; end
    if (err) nerr = nerr + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input int pad, input logic dly, input logic en,
                           input logic ff, input int mult, input logic stall, input int hold);
    int c0, d, total, bad, padv, last;
    bit ok;
    ncap = 0; nirq = 0; nerr = 0; idx = 0; took = 0;
    @(negedge clk);
    desc_len = 16'(len); desc_pad = 4'(pad); desc_dly = dly; cfg_dly_en = en;
    cfg_idle_ff = ff; cfg_dly_mult = 8'(mult); desc_valid = 1;
    fifo_rdy = 1; data_valid = 1; data_byte = 8'h30;
    @(posedge clk); #1;
    desc_valid = 0; c0 = cyc;
    if (hold > 0) fifo_rdy = 0;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      if (took) begin idx++; took = 0; end
      data_byte = 8'(8'h30 + idx);
      if (hold > 0 && cyc - c0 < hold) fifo_rdy = 0;
      else if (stall) begin
        fifo_rdy = (cyc % 3) != 0;
        data_valid = (cyc % 4) != 1;
      end else begin
        fifo_rdy = 1; data_valid = 1;
      end
      if (hold > 0 && cyc - c0 == hold - 1) begin
        @(negedge clk);
        chk(ncap == 0 && !data_req, "R8 no write while fifo_rdy low", ncap, 0);
      end
      if (nirq > 0 && cyc == irq_cyc + 1) break;
    end
    @(negedge clk);
    chk(desc_ready && !fifo_wr, "R9 idle after irq", int'(desc_ready), 1);
    fifo_rdy = 1; data_valid = 1;
    total = len + 1 + pad;
    chk(ncap == total, stall ? "R8 byte count under stall" : "R1 byte count", ncap, total);
    bad = 0;
    for (int k = 0; k < len && k < ncap; k++) if (cap[k] != 8'(8'h30 + k)) bad++;
    chk(bad == 0, stall ? "R8 data order under stall" : "R1 data order", bad, 0);
    chk(ncap > len && cap[len] == 8'h7E, "R2 closing flag", (ncap > len) ? int'(cap[len]) : -1, 'h7E);
    padv = ff ? 'hFF : 'h7E;
    bad = 0;
    for (int k = len + 1; k < ncap; k++) if (cap[k] != 8'(padv)) bad++;
    chk(bad == 0 && ncap == total, "R3 pad bytes", bad, 0);
    last = (ncap > 0) ? capcyc[ncap-1] : -100;
    chk(nirq == 1 && irq_cyc == last + 1, "R4 irq after last write", irq_cyc - last, 1);
    if (!stall && hold == 0) begin
      d = (dly && en) ? mult * TICK : 0;
      ok = ncap > 0 && capcyc[0] - c0 == d;
      chk(ok, (dly && !en) ? "R6 delay flag ignored" : "R5 delay to first byte",
          (ncap > 0) ? capcyc[0] - c0 : -1, d);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(desc_ready && !fifo_wr && !data_req && !irq && !err, "R10 reset state", int'(desc_ready), 1);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      e = VEC[v];
      run_frame(int'(e[19:12]), int'(e[11:8]), e[7], e[6], e[5], int'(e[4:1]), e[0], 0);
    end

    run_frame(3, 1, 1'b0, 1'b0, 1'b1, 0, 1'b0, 10);

    ncap = 0; nirq = 0; nerr = 0;
    @(negedge clk);
    desc_len = '0; desc_pad = 4'd3; desc_dly = 0; desc_valid = 1;
    @(posedge clk); #1;
    desc_valid = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(nerr == 1, "R7 error pulse", nerr, 1);
    chk(ncap == 0 && nirq == 0 && desc_ready, "R7 nothing emitted", ncap + nirq, 0);

    run_frame(1, 15, 1'b1, 1'b1, 1'b1, 2, 1'b0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R4 watchdog: actual %0d cycles, expected completion sooner", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule